// File: doc/BRIEF.md
# Three-Level Processor Reset Sequencer

This block sits on the system side of a processor and drives the processor's three reset-related inputs: a power-good level, an active-low cold reset and an active-low warm reset. It runs on the processor's master clock. It accepts three kinds of request, each resetting a different amount of the processor. A power-on request performs the deepest reset. A cold request performs most of that sequence again. A warm request only pulses warm reset. Each deeper reset contains the shallower ones.

For every request the block applies the three signals in the order the processor needs and holds each one for its minimum time. It releases every reset on a rising clock edge. When the sequence ends it reports which kind of reset finished. Every duration is a parameter, so a testbench can shorten the production values of tens of thousands of cycles.

After the hardware reset input is applied, the block starts a power-on sequence by itself. It raises power-good only after the power-stable input has been true for the settling interval.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pwr_good_o`=0, `cold_rst_n_o`=0, `warm_rst_n_o`=0, `busy_o`=1, `done_o`=0 and `done_kind_o`=2'b00. The block then runs a power-on sequence without any request.
- R2: In a power-on sequence, `pwr_good_o` rises only after `pwr_stable_i` has been high for `SETTLE_CYC` consecutive cycles. Any cycle with `pwr_stable_i` low restarts this count.
- R3: `pwr_good_o` never rises while `cold_rst_n_o` is high.
- R4: After `pwr_good_o` rises, `cold_rst_n_o` stays low for exactly `COLD_HOLD_CYC` cycles.
- R5: `warm_rst_n_o` is low whenever `cold_rst_n_o` is low. After cold reset is released, warm reset stays low for exactly `WARM_TAIL_CYC` more cycles.
- R6: A cold request drives `pwr_good_o` low for `PG_OFF_CYC` cycles with both resets asserted. The sequence then continues with the timing of R4 and R5.
- R7: A warm request drives only `warm_rst_n_o` low, for exactly `WARM_ONLY_CYC` cycles. During this time `pwr_good_o` stays 1 and `cold_rst_n_o` stays 1.
- R8: A request that arrives while `busy_o` is 1 is ignored. The running sequence keeps its kind and its durations.
- R9: When requests arrive in the same idle cycle, power-on wins over cold, and cold wins over warm.
- R10: `done_o` is high for exactly one cycle: the first cycle in which `warm_rst_n_o` is high again. In that same cycle `busy_o` is 0. `done_kind_o` shows 2'b01 after power-on, 2'b10 after cold and 2'b11 after warm, and holds that value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| pwr_stable_i | input | 1 | Supply is stable |
| req_por_i | input | 1 | Power-on reset request pulse |
| req_cold_i | input | 1 | Cold reset request pulse |
| req_warm_i | input | 1 | Warm reset request pulse |
| pwr_good_o | output | 1 | Power-good level to the processor |
| cold_rst_n_o | output | 1 | Active-low cold reset to the processor |
| warm_rst_n_o | output | 1 | Active-low warm reset to the processor |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle completion pulse |
| done_kind_o | output | 2 | Kind of the last completed reset |

## Verification
Two kinds of coincidence are provoked here.

The first is arbitration. Two requests are raised in the same idle cycle: cold with warm, and power-on with cold. The winner is judged at the ports. Its power-good low time and its completion code must match the kind that ought to win.

The second is a request that lands while a sequence is running. A cold pulse is driven in the middle of a warm-only reset. That pulse must leave power-good high, keep the warm-only duration exact, and report a warm completion.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PG_OFF,
        ST_COLD_HOLD,
        ST_WARM_TAIL,
        ST_WARM_ONLY
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_POR  = 2'b01,
        KIND_COLD = 2'b10,
        KIND_WARM = 2'b11
    } rst_kind_e;

    typedef struct packed {
        logic pwr_good;
        logic cold_n;
        logic warm_n;
        logic busy;
    } pin_set_t;

    // Level of every processor-facing pin for a given phase.
    function automatic pin_set_t pins_for(seq_state_e s);
        pin_set_t p;
        p.pwr_good = !(s == ST_SETTLE || s == ST_PG_OFF);
        p.cold_n   = !(s == ST_SETTLE || s == ST_PG_OFF || s == ST_COLD_HOLD);
        p.warm_n   = (s == ST_IDLE);
        p.busy     = (s != ST_IDLE);
        return p;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rst_seq_arb.sv
module rst_seq_arb
    import rst_seq_pkg::*;
(
    input  logic      accept,
    input  logic      req_por,
    input  logic      req_cold,
    input  logic      req_warm,
    output rst_kind_e pick
);

    always_comb begin
        if (!accept)       pick = KIND_NONE;
        else if (req_por)  pick = KIND_POR;
        else if (req_cold) pick = KIND_COLD;
        else if (req_warm) pick = KIND_WARM;
        else               pick = KIND_NONE;
    end

    // R9: a deeper request is never beaten by warm
    always_comb begin
        if (accept && (req_por || req_cold)) begin
            assert_deeper_wins_R9: assert (pick != KIND_WARM);
        end
    end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int SETTLE_CYC    = 4096,
    parameter int PG_OFF_CYC    = 65536,
    parameter int COLD_HOLD_CYC = 65536,
    parameter int WARM_TAIL_CYC = 64,
    parameter int WARM_ONLY_CYC = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_stable_i,
    input  logic       req_por_i,
    input  logic       req_cold_i,
    input  logic       req_warm_i,
    output logic       pwr_good_o,
    output logic       cold_rst_n_o,
    output logic       warm_rst_n_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] done_kind_o
);

    localparam int MAX_LEN = max_of(max_of(max_of(SETTLE_CYC, PG_OFF_CYC),
                                           max_of(COLD_HOLD_CYC, WARM_TAIL_CYC)),
                                    WARM_ONLY_CYC);
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] TC_SETTLE = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TC_PG_OFF = CNT_W'(PG_OFF_CYC - 1);
    localparam logic [CNT_W-1:0] TC_COLD   = CNT_W'(COLD_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] TC_TAIL   = CNT_W'(WARM_TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] TC_WONLY  = CNT_W'(WARM_ONLY_CYC - 1);

    seq_state_e       state_q, state_d;
    rst_kind_e        pick, cur_kind_q, done_kind_q;
    pin_set_t         pins_q;
    logic             done_q;
    logic             tmr_clr, tmr_en;
    logic [CNT_W-1:0] cnt;

    rst_seq_arb u_arb (
        .accept   (state_q == ST_IDLE),
        .req_por  (req_por_i),
        .req_cold (req_cold_i),
        .req_warm (req_warm_i),
        .pick     (pick)
    );

    rst_seq_timer #(.W(CNT_W)) u_tmr (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .en  (tmr_en),
        .cnt (cnt)
    );

    always_comb begin
        state_d = state_q;
        tmr_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                unique case (pick)
                    KIND_POR:  state_d = ST_SETTLE;
                    KIND_COLD: state_d = ST_PG_OFF;
                    KIND_WARM: state_d = ST_WARM_ONLY;
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_SETTLE: begin
                if (!pwr_stable_i)         tmr_clr = 1'b1;
                else if (cnt == TC_SETTLE) state_d = ST_COLD_HOLD;
            end
            ST_PG_OFF:    if (cnt == TC_PG_OFF) state_d = ST_COLD_HOLD;
            ST_COLD_HOLD: if (cnt == TC_COLD)   state_d = ST_WARM_TAIL;
            ST_WARM_TAIL: if (cnt == TC_TAIL)   state_d = ST_IDLE;
            ST_WARM_ONLY: if (cnt == TC_WONLY)  state_d = ST_IDLE;
            default:      state_d = ST_SETTLE;
        endcase
        if (state_d != state_q || state_q == ST_IDLE) tmr_clr = 1'b1;
        tmr_en = !tmr_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_SETTLE;
            pins_q      <= pins_for(ST_SETTLE);
            cur_kind_q  <= KIND_POR;
            done_q      <= 1'b0;
            done_kind_q <= KIND_NONE;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_for(state_d);
            if (state_q == ST_IDLE && pick != KIND_NONE) cur_kind_q <= pick;
            done_q <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if ((state_q != ST_IDLE) && (state_d == ST_IDLE)) done_kind_q <= cur_kind_q;
        end
    end

    assign pwr_good_o   = pins_q.pwr_good;
    assign cold_rst_n_o = pins_q.cold_n;
    assign warm_rst_n_o = pins_q.warm_n;
    assign busy_o       = pins_q.busy;
    assign done_o       = done_q;
    assign done_kind_o  = done_kind_q;

    // R3: power-good only rises under cold reset
    assert_pg_under_cold_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good_o) |-> !cold_rst_n_o);

    // R5: warm reset never released ahead of cold reset
    assert_warm_covers_cold_R5: assert property (@(posedge clk) disable iff (rst)
        !cold_rst_n_o |-> !warm_rst_n_o);

    // R6: power-good only falls with both resets asserted
    assert_pg_drop_resets_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_good_o) |-> (!cold_rst_n_o && !warm_rst_n_o));

    // R7: a warm-only phase keeps power-good and cold reset released
    assert_warm_only_pins_R7: assert property (@(posedge clk) disable iff (rst)
        (pwr_good_o && cold_rst_n_o && !warm_rst_n_o) |=> (pwr_good_o && cold_rst_n_o));

    // R8: the running kind is frozen while busy
    assert_busy_holds_kind_R8: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (!busy_o || $stable(cur_kind_q)));

    // R10: done is a single pulse, aligned with warm release
    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_at_release_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(warm_rst_n_o) |-> (done_o && !busy_o));

endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;

    localparam int T_SET  = 5;
    localparam int T_OFF  = 4;
    localparam int T_COLD = 20;
    localparam int T_TAIL = 6;
    localparam int T_WO   = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_stable = 1'b0;
    logic req_por = 1'b0, req_cold = 1'b0, req_warm = 1'b0;
    logic pg, cold_n, warm_n, busy, done;
    logic [1:0] kind;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rst_seq_ctrl #(
        .SETTLE_CYC(T_SET), .PG_OFF_CYC(T_OFF), .COLD_HOLD_CYC(T_COLD),
        .WARM_TAIL_CYC(T_TAIL), .WARM_ONLY_CYC(T_WO)
    ) dut_i (
        .clk(clk), .rst(rst), .pwr_stable_i(pwr_stable),
        .req_por_i(req_por), .req_cold_i(req_cold), .req_warm_i(req_warm),
        .pwr_good_o(pg), .cold_rst_n_o(cold_n), .warm_rst_n_o(warm_n),
        .busy_o(busy), .done_o(done), .done_kind_o(kind)
    );

    // Stimulus table: request code 1=power-on 2=cold 3=warm
    localparam int NV = 5;
    localparam int VEC_REQ [NV] = '{3, 2, 1, 3, 2};

    function automatic int exp_lo(int r);
        return (r == 1) ? T_SET : (r == 2) ? T_OFF : 0;
    endfunction
    function automatic int exp_cold(int r);
        return (r == 3) ? 0 : T_COLD;
    endfunction
    function automatic int exp_tail(int r);
        return (r == 3) ? T_WO : T_TAIL;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit p, input bit c, input bit w);
        req_por = p; req_cold = c; req_warm = w;
        @(negedge clk);
        req_por = 1'b0; req_cold = 1'b0; req_warm = 1'b0;
    endtask

    // Counts phases from the current sample until done, then checks one pulse.
    task automatic measure(output int lo, output int ch, output int tl, output int k,
                           input bit mid_cold);
        int n = 0;
        lo = 0; ch = 0; tl = 0;
        while (!done && n < 2000) begin
            if (!cold_n && warm_n) check(0, "R5 warm released early", 1, 0);
            if (!pg)          lo++;
            else if (!cold_n) ch++;
            else if (!warm_n) tl++;
            if (mid_cold && n == 2) req_cold = 1'b1;
            else req_cold = 1'b0;
            n++;
            @(negedge clk);
        end
        req_cold = 1'b0;
        k = int'(kind);
        check(busy == 1'b0, "R10 busy at done", int'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done single cycle", int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int lo, ch, tl, k;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pg == 0 && cold_n == 0 && warm_n == 0, "R1 pins in reset", {pg, cold_n, warm_n}, 0);
        check(busy == 1 && done == 0 && kind == 2'b00, "R1 status in reset", {busy, done, kind}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        check(pg == 0 && cold_n == 0 && warm_n == 0 && busy == 1, "R1 first cycle", {pg, cold_n, warm_n, busy}, 1);
        // R2: no power-good without stable supply
        repeat (10) @(negedge clk);
        check(pg == 0, "R2 pg waits for stable", int'(pg), 0);
        pwr_stable = 1'b1;
        measure(lo, ch, tl, k, 1'b0);
        check(lo == T_SET, "R2 settle length", lo, T_SET);
        check(ch == T_COLD, "R4 cold hold", ch, T_COLD);
        check(tl == T_TAIL, "R5 warm tail", tl, T_TAIL);
        check(k == 1, "R10 kind power-on", k, 1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            int r = VEC_REQ[i];
            pulse(r == 1, r == 2, r == 3);
            measure(lo, ch, tl, k, 1'b0);
            check(lo == exp_lo(r), (r == 2) ? "R6 pg off" : "R2/R7 pg low", lo, exp_lo(r));
            check(ch == exp_cold(r), (r == 3) ? "R7 cold untouched" : "R4 cold hold", ch, exp_cold(r));
            check(tl == exp_tail(r), (r == 3) ? "R7 warm only" : "R5 warm tail", tl, exp_tail(r));
            check(k == r, "R10 kind code", k, r);
        end

        // R2: supply loss during settle restarts the count
        pwr_stable = 1'b0;
        pulse(1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        pwr_stable = 1'b1;
        repeat (3) @(negedge clk);
        pwr_stable = 1'b0;
        repeat (2) @(negedge clk);
        check(pg == 0, "R2 pg low after dropout", int'(pg), 0);
        pwr_stable = 1'b1;
        measure(lo, ch, tl, k, 1'b0);
        check(lo == T_SET, "R2 restarted settle", lo, T_SET);

        // R8: cold pulse during warm-only is ignored
        pulse(1'b0, 1'b0, 1'b1);
        measure(lo, ch, tl, k, 1'b1);
        check(lo == 0, "R8 pg unaffected", lo, 0);
        check(tl == T_WO, "R8 warm length kept", tl, T_WO);
        check(k == 3, "R8 kind stays warm", k, 3);

        // R9: cold beats warm, power-on beats cold
        pulse(1'b0, 1'b1, 1'b1);
        measure(lo, ch, tl, k, 1'b0);
        check(lo == T_OFF && k == 2, "R9 cold over warm", k, 2);
        pulse(1'b1, 1'b1, 1'b0);
        measure(lo, ch, tl, k, 1'b0);
        check(lo == T_SET && k == 1, "R9 power-on over cold", k, 1);

        // R10: kind code held while idle
        repeat (5) @(negedge clk);
        check(kind == 2'b01 && busy == 0, "R10 kind held", int'(kind), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule